// File: doc/BRIEF.md
# CAN Initialization and Bus-Integration Controller

This block decides when a CAN protocol controller may take part in bus traffic. It holds an initialization flag and a configuration-enable flag. The initialization flag is raised by a CPU register write, by hardware reset, or by a bus-off report from the error logic. While that flag is up, the block keeps the transmit line recessive, refuses every transfer grant, and keeps the new-data and remote-pending flags of the highest-numbered message object cleared. The bit-timing register can be written only while configuration is enabled.

Once software lowers the initialization flag, the block watches the sampled receive bits. It opens the bus to the protocol engine only after it has counted eleven recessive samples in a row. The valid bits of the message objects can be written at any time. A transfer request for an object is granted only when the bus is open and that object is valid. Error counters live outside the block, and the block never touches them.

Top module: `can_init_ctrl`

## Requirements
- R1: After reset, init_o is 1, cce_o is 0, btr_o holds BTR_DEFAULT (16'h2301), bus_active_o is 0, idle_cnt_o is 0, and obj_valid_o is all zero.
- R2: A CPU write to address 0 loads init_o from data bit 0 and cce_o from data bit 1. The new values are visible in the cycle after the write.
- R3: A busoff_i pulse sets init_o in the following cycle. When busoff_i coincides with a CPU write that clears bit 0 of address 0, init_o still becomes 1.
- R4: While init_o is 1, tx_o is 1 (recessive) and grant_o is 0, whatever core_tx_i and the request inputs are.
- R5: While init_o is 1, last_newdat_o and last_rmtpnd_o read 0, and the set pulses set_newdat_i / set_rmtpnd_i have no effect. While init_o is 0, those pulses set the flags, and a write to address 3 clears them (bit 0 for new-data, bit 1 for remote-pending).
- R6: A write to address 1 loads btr_o only when cce_o is 1 at the time of the write. Otherwise the write is ignored and btr_o keeps its value.
- R7: After init_o falls, bus_active_o rises in the cycle after the eleventh consecutive recessive sample (bit_strobe_i=1, rx_bit_i=1), and not earlier.
- R8: idle_cnt_o changes only on cycles with bit_strobe_i=1. It returns to 0 on a dominant sample and saturates at 11.
- R9: When init_o rises, bus_active_o is 0 in that same cycle, and idle_cnt_o is 0 in the next cycle.
- R10: A write to address 2 loads obj_valid_o whether init_o is 1 or 0. grant_o is 1 only when bus_active_o is 1, req_vld_i is 1 and object req_obj_i is valid.
- R11: While bus_active_o is 1, tx_o follows core_tx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 2 | Register address: 0 control, 1 bit timing, 2 object valid, 3 flag clear |
| cpu_wdata_i | input | DATA_W | CPU write data |
| busoff_i | input | 1 | Bus-off entry pulse from the error logic |
| bit_strobe_i | input | 1 | One-cycle strobe marking a sampled bus bit |
| rx_bit_i | input | 1 | Sampled receive bit (1 = recessive) |
| core_tx_i | input | 1 | Transmit bit from the protocol engine |
| set_newdat_i | input | 1 | Sets the new-data flag of the last object |
| set_rmtpnd_i | input | 1 | Sets the remote-pending flag of the last object |
| req_vld_i | input | 1 | Protocol engine requests a transfer |
| req_obj_i | input | OBJ_W | Object index of the request |
| init_o | output | 1 | Initialization flag |
| cce_o | output | 1 | Configuration-enable flag |
| btr_o | output | DATA_W | Bit-timing register contents |
| bus_active_o | output | 1 | Bus integration complete, transfers allowed |
| idle_cnt_o | output | CNT_W | Consecutive recessive sample count |
| tx_o | output | 1 | Transmit line |
| xfer_en_o | output | 1 | Message transfer enable |
| grant_o | output | 1 | Grant for the current request |
| obj_valid_o | output | NUM_OBJ | Message object valid bits |
| last_newdat_o | output | 1 | New-data flag of the last object |
| last_rmtpnd_o | output | 1 | Remote-pending flag of the last object |

## Verification
Two events can fall in the same cycle: a bus-off report from the error logic, and a CPU write that lowers the initialization flag. The bench drives busoff_i and a control write with bit 0 clear on the same clock edge. It then judges that init_o is 1 in the next cycle and that the idle counter never started. A second collision is a bus-off report arriving after integration is complete. In that case bus_active_o and tx_o must return to their idle values in the very cycle init_o rises.

// File: rtl/can_init_pkg.sv
// Package: shared register addresses and defaults for the CAN init controller.
// Assumes a 2-bit word address space local to this block.
package can_init_pkg;

    typedef enum logic [1:0] {
        RA_CTRL    = 2'd0,  // bit0 init, bit1 cce
        RA_TIMING  = 2'd1,  // bit timing value, guarded by cce
        RA_VALID   = 2'd2,  // one valid bit per message object
        RA_FLAGCLR = 2'd3   // bit0 clears new-data, bit1 clears remote-pending
    } reg_addr_e;

    localparam int CTRL_INIT_BIT = 0;
    localparam int CTRL_CCE_BIT  = 1;
    localparam int CLR_NEWDAT_BIT = 0;
    localparam int CLR_RMTPND_BIT = 1;

endpackage

// File: rtl/can_init_ctlreg.sv
// Module: control and bit-timing registers.
// Holds the init and configuration-enable flags and the bit-timing value.
// Assumes busoff_i is a pulse from the error logic; bus-off overrides a
// simultaneous CPU clear of init. Timing writes are checked against the
// registered cce value, so enabling and writing take two separate writes.
module can_init_ctlreg
    import can_init_pkg::*;
#(
    parameter int             DATA_W      = 16,
    parameter logic [DATA_W-1:0] BTR_DEFAULT = 16'h2301
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busoff_i,
    output logic              init_o,
    output logic              cce_o,
    output logic [DATA_W-1:0] btr_o
);

    logic              init_q;
    logic              cce_q;
    logic [DATA_W-1:0] btr_q;
    logic              ctrl_wr;
    logic              tim_wr;

    // Purpose: decode the write strobes for this register group.
    always_comb begin
        ctrl_wr = wr_i && (addr_i == RA_CTRL);
        tim_wr  = wr_i && (addr_i == RA_TIMING) && cce_q;
    end

    // Purpose: init flag, bus-off has priority over a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b1;
        end else if (busoff_i) begin
            init_q <= 1'b1;
        end else if (ctrl_wr) begin
            init_q <= wdata_i[CTRL_INIT_BIT];
        end
    end

    // Purpose: configuration-enable flag, written only by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cce_q <= 1'b0;
        end else if (ctrl_wr) begin
            cce_q <= wdata_i[CTRL_CCE_BIT];
        end
    end

    // Purpose: bit-timing register, writable only while cce is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btr_q <= BTR_DEFAULT;
        end else if (tim_wr) begin
            btr_q <= wdata_i;
        end
    end

    assign init_o = init_q;
    assign cce_o  = cce_q;
    assign btr_o  = btr_q;

endmodule

// File: rtl/can_idle_detect.sv
// Module: bus-idle detector for integration after initialization.
// Counts consecutive recessive samples on bit strobes while init is low;
// declares the bus usable after IDLE_BITS of them. Once usable, stays
// usable until init returns. Assumes bit_strobe_i is a one-cycle pulse.
module can_idle_detect #(
    parameter int IDLE_BITS = 11,
    parameter int CNT_W     = $clog2(IDLE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             strobe_i,
    input  logic             rx_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Purpose: saturating recessive-run counter and the integration flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (init_i) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (strobe_i) begin
            if (rx_i) begin
                if (cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (cnt_q == CNT_LAST) begin
                    active_q <= 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign active_o = active_q & ~init_i;

endmodule

// File: rtl/can_msg_gate.sv
// Module: message object valid bits, last-object flags and transfer grant.
// Valid bits are writable at any time. The last object's flags are forced
// clear while init is high. A grant needs an open bus and a valid object.
module can_msg_gate
    import can_init_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_OBJ = 15,
    parameter int OBJ_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               init_i,
    input  logic               active_i,
    input  logic               set_newdat_i,
    input  logic               set_rmtpnd_i,
    input  logic               req_vld_i,
    input  logic [OBJ_W-1:0]   req_obj_i,
    output logic [NUM_OBJ-1:0] valid_o,
    output logic               newdat_o,
    output logic               rmtpnd_o,
    output logic               grant_o
);

    localparam int PAD_N = 2 ** OBJ_W;

    logic [NUM_OBJ-1:0] valid_q;
    logic               newdat_q;
    logic               rmtpnd_q;
    logic               clr_wr;
    logic [PAD_N-1:0]   valid_pad;

    // Purpose: valid bits load on every write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_i && (addr_i == RA_VALID)) begin
            valid_q <= wdata_i[NUM_OBJ-1:0];
        end
    end

    assign clr_wr = wr_i && (addr_i == RA_FLAGCLR);

    // Purpose: last-object flags, held clear during initialization.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            newdat_q <= 1'b0;
            rmtpnd_q <= 1'b0;
        end else begin
            if (set_newdat_i) begin
                newdat_q <= 1'b1;
            end else if (clr_wr && wdata_i[CLR_NEWDAT_BIT]) begin
                newdat_q <= 1'b0;
            end
            if (set_rmtpnd_i) begin
                rmtpnd_q <= 1'b1;
            end else if (clr_wr && wdata_i[CLR_RMTPND_BIT]) begin
                rmtpnd_q <= 1'b0;
            end
        end
    end

    // Purpose: pad the valid vector so any request index selects safely.
    always_comb begin
        valid_pad = '0;
        valid_pad[NUM_OBJ-1:0] = valid_q;
    end

    assign valid_o  = valid_q;
    assign newdat_o = newdat_q & ~init_i;
    assign rmtpnd_o = rmtpnd_q & ~init_i;
    assign grant_o  = active_i & req_vld_i & valid_pad[req_obj_i];

endmodule

// File: rtl/can_init_ctrl.sv
// Module: top of the CAN initialization and bus-integration controller.
// Ties the register group, the idle detector and the message gate together
// and shapes the transmit line. Assumes one CPU write per cycle and
// samples from the bit timing logic delivered with a one-cycle strobe.
module can_init_ctrl
    import can_init_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                NUM_OBJ     = 15,
    parameter int                IDLE_BITS   = 11,
    parameter logic [DATA_W-1:0] BTR_DEFAULT = 16'h2301,
    localparam int               OBJ_W       = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int               CNT_W       = $clog2(IDLE_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr_i,
    input  logic [1:0]         cpu_addr_i,
    input  logic [DATA_W-1:0]  cpu_wdata_i,
    input  logic               busoff_i,
    input  logic               bit_strobe_i,
    input  logic               rx_bit_i,
    input  logic               core_tx_i,
    input  logic               set_newdat_i,
    input  logic               set_rmtpnd_i,
    input  logic               req_vld_i,
    input  logic [OBJ_W-1:0]   req_obj_i,
    output logic               init_o,
    output logic               cce_o,
    output logic [DATA_W-1:0]  btr_o,
    output logic               bus_active_o,
    output logic [CNT_W-1:0]   idle_cnt_o,
    output logic               tx_o,
    output logic               xfer_en_o,
    output logic               grant_o,
    output logic [NUM_OBJ-1:0] obj_valid_o,
    output logic               last_newdat_o,
    output logic               last_rmtpnd_o
);

    logic init_w;
    logic active_w;

    can_init_ctlreg #(
        .DATA_W     (DATA_W),
        .BTR_DEFAULT(BTR_DEFAULT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cpu_wr_i),
        .addr_i  (cpu_addr_i),
        .wdata_i (cpu_wdata_i),
        .busoff_i(busoff_i),
        .init_o  (init_w),
        .cce_o   (cce_o),
        .btr_o   (btr_o)
    );

    can_idle_detect #(
        .IDLE_BITS(IDLE_BITS),
        .CNT_W    (CNT_W)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (init_w),
        .strobe_i(bit_strobe_i),
        .rx_i    (rx_bit_i),
        .cnt_o   (idle_cnt_o),
        .active_o(active_w)
    );

    can_msg_gate #(
        .DATA_W (DATA_W),
        .NUM_OBJ(NUM_OBJ),
        .OBJ_W  (OBJ_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cpu_wr_i),
        .addr_i      (cpu_addr_i),
        .wdata_i     (cpu_wdata_i),
        .init_i      (init_w),
        .active_i    (active_w),
        .set_newdat_i(set_newdat_i),
        .set_rmtpnd_i(set_rmtpnd_i),
        .req_vld_i   (req_vld_i),
        .req_obj_i   (req_obj_i),
        .valid_o     (obj_valid_o),
        .newdat_o    (last_newdat_o),
        .rmtpnd_o    (last_rmtpnd_o),
        .grant_o     (grant_o)
    );

    // Purpose: recessive transmit line unless the bus has been joined.
    always_comb begin
        tx_o = (active_w && !init_w) ? core_tx_i : 1'b1;
    end

    assign init_o       = init_w;
    assign bus_active_o = active_w;
    assign xfer_en_o    = active_w;

endmodule

// File: rtl/can_init_ctrl_chk.sv
// Module: property checker for can_init_ctrl, attached by bind below.
// Observes ports only; makes no assumption about internal structure.
module can_init_ctrl_chk #(
    parameter int DATA_W    = 16,
    parameter int NUM_OBJ   = 15,
    parameter int IDLE_BITS = 11,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busoff_i,
    input logic              bit_strobe_i,
    input logic              init_o,
    input logic              cce_o,
    input logic [DATA_W-1:0] btr_o,
    input logic              bus_active_o,
    input logic [CNT_W-1:0]  idle_cnt_o,
    input logic              tx_o,
    input logic              grant_o,
    input logic              last_newdat_o,
    input logic              last_rmtpnd_o
);

    AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> tx_o);  // R4
    AST_NO_GRANT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !grant_o);  // R4
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> (!last_newdat_o && !last_rmtpnd_o));  // R5
    AST_BUSOFF_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_i |=> init_o);  // R3
    AST_BTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cce_o |=> $stable(btr_o));  // R6
    AST_ACTIVE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active_o) |-> (idle_cnt_o == CNT_W'(IDLE_BITS)));  // R7
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt_o <= CNT_W'(IDLE_BITS));  // R8
    AST_CNT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe_i && !init_o) |=> $stable(idle_cnt_o));  // R8
    AST_INIT_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !bus_active_o);  // R9
    AST_INIT_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> (idle_cnt_o == '0));  // R9

endmodule

bind can_init_ctrl can_init_ctrl_chk #(
    .DATA_W   (DATA_W),
    .NUM_OBJ  (NUM_OBJ),
    .IDLE_BITS(IDLE_BITS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busoff_i     (busoff_i),
    .bit_strobe_i (bit_strobe_i),
    .init_o       (init_o),
    .cce_o        (cce_o),
    .btr_o        (btr_o),
    .bus_active_o (bus_active_o),
    .idle_cnt_o   (idle_cnt_o),
    .tx_o         (tx_o),
    .grant_o      (grant_o),
    .last_newdat_o(last_newdat_o),
    .last_rmtpnd_o(last_rmtpnd_o)
);

// File: tb/can_init_ctrl_tb_top.sv
// Directed bench for can_init_ctrl: one task per scenario, each checking itself.
module can_init_ctrl_tb_top;

    localparam int          DATA_W = 16;
    localparam int          NUM_OBJ = 15;
    localparam logic [15:0] BTR_DEF = 16'h2301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        busoff = 1'b0;
    logic        strobe = 1'b0;
    logic        rx = 1'b1;
    logic        core_tx = 1'b1;
    logic        set_nd = 1'b0;
    logic        set_rp = 1'b0;
    logic        req_vld = 1'b0;
    logic [3:0]  req_obj = '0;

    logic        init_o, cce_o, bus_active_o, tx_o, xfer_en_o, grant_o;
    logic        last_nd_o, last_rp_o;
    logic [15:0] btr_o;
    logic [3:0]  cnt_o;
    logic [14:0] valid_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    can_init_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .busoff_i(busoff), .bit_strobe_i(strobe),
        .rx_bit_i(rx), .core_tx_i(core_tx), .set_newdat_i(set_nd),
        .set_rmtpnd_i(set_rp), .req_vld_i(req_vld), .req_obj_i(req_obj),
        .init_o(init_o), .cce_o(cce_o), .btr_o(btr_o),
        .bus_active_o(bus_active_o), .idle_cnt_o(cnt_o), .tx_o(tx_o),
        .xfer_en_o(xfer_en_o), .grant_o(grant_o), .obj_valid_o(valid_o),
        .last_newdat_o(last_nd_o), .last_rmtpnd_o(last_rp_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        strobe = 1'b1; rx = b;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic integrate();
        cpu_write(2'd0, 16'h0000);
        for (int i = 0; i < 11; i++) send_bit(1'b1);
    endtask

    task automatic t_reset();
        chk("R1 init", init_o, 1);
        chk("R1 cce", cce_o, 0);
        chk("R1 btr", btr_o, BTR_DEF);
        chk("R1 active", bus_active_o, 0);
        chk("R1 cnt", cnt_o, 0);
        chk("R1 valid", valid_o, 0);
        chk("R4 tx recessive", tx_o, 1);
    endtask

    task automatic t_timing();
        cpu_write(2'd1, 16'h1234);
        chk("R6 locked write ignored", btr_o, BTR_DEF);
        cpu_write(2'd0, 16'h0003);
        chk("R2 cce set", cce_o, 1);
        chk("R2 init kept", init_o, 1);
        cpu_write(2'd1, 16'h1234);
        chk("R6 unlocked write", btr_o, 16'h1234);
        cpu_write(2'd0, 16'h0001);
        cpu_write(2'd1, 16'h5555);
        chk("R6 relocked write ignored", btr_o, 16'h1234);
    endtask

    task automatic t_init_hold();
        core_tx = 1'b0; req_vld = 1'b1; req_obj = 4'd0;
        @(negedge clk); set_nd = 1'b1; set_rp = 1'b1;
        @(negedge clk); set_nd = 1'b0; set_rp = 1'b0;
        chk("R5 newdat held clear", last_nd_o, 0);
        chk("R5 rmtpnd held clear", last_rp_o, 0);
        cpu_write(2'd2, 16'h0005);
        chk("R10 valid write during init", valid_o, 15'h0005);
        chk("R4 tx recessive despite core", tx_o, 1);
        chk("R4 no grant in init", grant_o, 0);
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        chk("R9 no count during init", cnt_o, 0);
        core_tx = 1'b1; req_vld = 1'b0;
    endtask

    task automatic t_integrate();
        cpu_write(2'd0, 16'h0000);
        chk("R2 init cleared", init_o, 0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        chk("R7 not active after 10", bus_active_o, 0);
        chk("R8 count 10", cnt_o, 10);
        send_bit(1'b0);
        chk("R8 dominant resets", cnt_o, 0);
        send_bit(1'b1);
        rx = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 no strobe no change", cnt_o, 1);
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk("R7 not active after 10 again", bus_active_o, 0);
        send_bit(1'b1);
        chk("R7 active after 11", bus_active_o, 1);
        chk("R7 xfer enabled", xfer_en_o, 1);
        send_bit(1'b1); send_bit(1'b1);
        chk("R8 saturates at 11", cnt_o, 11);
        @(negedge clk); core_tx = 1'b0;
        #1 chk("R11 tx follows core 0", tx_o, 0);
        core_tx = 1'b1;
        #1 chk("R11 tx follows core 1", tx_o, 1);
        req_vld = 1'b1; req_obj = 4'd2;
        #1 chk("R10 grant for valid object", grant_o, 1);
        req_obj = 4'd1;
        #1 chk("R10 no grant invalid object", grant_o, 0);
        req_vld = 1'b0;
        cpu_write(2'd2, 16'h0002);
        req_vld = 1'b1;
        #1 chk("R10 valid write while active", grant_o, 1);
        req_vld = 1'b0;
        @(negedge clk); set_nd = 1'b1; set_rp = 1'b1;
        @(negedge clk); set_nd = 1'b0; set_rp = 1'b0;
        chk("R5 newdat set when running", last_nd_o, 1);
        chk("R5 rmtpnd set when running", last_rp_o, 1);
        cpu_write(2'd3, 16'h0001);
        chk("R5 newdat cleared by write", last_nd_o, 0);
        chk("R5 rmtpnd kept", last_rp_o, 1);
    endtask

    task automatic t_reinit();
        core_tx = 1'b0;
        cpu_write(2'd0, 16'h0001);
        chk("R2 init set by write", init_o, 1);
        chk("R9 active drops same cycle", bus_active_o, 0);
        chk("R4 tx recessive on reinit", tx_o, 1);
        chk("R5 rmtpnd cleared on reinit", last_rp_o, 0);
        @(negedge clk);
        chk("R9 count cleared", cnt_o, 0);
        core_tx = 1'b1;
    endtask

    task automatic t_busoff();
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 2'd0; cpu_wdata = 16'h0000; busoff = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; busoff = 1'b0;
        chk("R3 busoff beats clear", init_o, 1);
        send_bit(1'b1);
        chk("R3 no integration after collision", cnt_o, 0);
        integrate();
        chk("R7 active before busoff", bus_active_o, 1);
        @(negedge clk); busoff = 1'b1;
        @(negedge clk); busoff = 1'b0;
        chk("R3 busoff sets init", init_o, 1);
        chk("R9 active drops on busoff", bus_active_o, 0);
        chk("R6 btr untouched by busoff", btr_o, 16'h1234);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_timing();
                t_init_hold();
                t_integrate();
                t_reinit();
                t_busoff();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule